// File: doc/BRIEF.md
# Pending Exception Priority Arbiter

This block holds the exception requests raised inside a processor core and chooses which one the core services next. A producer posts a request by presenting an 8-bit vector number with a strobe. The block keeps one pending bit for each possible vector.

Interrupt requests are held back while their level does not exceed the current 3-bit interrupt mask. The remaining requests are ranked by a fixed class that depends on the vector number. The winner is shown with a valid flag, and it is retired by an acknowledge. With the acknowledge, the consumer can report that fetching the handler address failed. The block then posts the follow-up request itself, or it raises a sticky halt flag when the failure cannot be recovered.

A wake output tells the core to leave its stopped state whenever a request that may end a stop is posted.

Top module: `exc_arbiter`

## Requirements
- R1: After synchronous active-high reset, nothing is pending: `sel_valid` and `halted` are 0.
- R2: A vector posted with `post_valid` shows on `sel_vec` with `sel_valid` high from the next cycle. A cycle with `take` high while `sel_valid` is high clears the shown request.
- R3: Selection follows class order, most urgent first:
  - vector 3;
  - vector 2;
  - vector 9;
  - vectors 24..31 and 64..255;
  - vector 4;
  - vector 8;
  - every other vector.
- R4: Among pending eligible requests of one class, the lowest vector number is shown.
- R5: Vectors 25..31 and 57..63 are interrupts whose level is the vector's bits [2:0]. Such a request stays pending but cannot be shown while its level is at or below `irq_mask`. It becomes eligible once the mask drops below its level.
- R6: While vector 0 is pending, it is shown ahead of every other request. Taking it clears all pending requests.
- R7: `wake` is high in the same cycle as a post of vector 0, vector 9, vectors 25..31 or vectors 57..63. It is low for any other post and when nothing is posted.
- R8: Taking an interrupt request with `fetch_fault` high posts vector 24 in its place.
- R9: Taking vector 2 with `fetch_fault` high sets `halted`, which stays set until reset. Taking any other non-interrupt, non-zero vector with `fetch_fault` high posts vector 2.
- R10: Posting a vector that is already pending has no further effect: a single take removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_valid | input | 1 | Post strobe |
| post_vec | input | 8 | Vector being posted |
| irq_mask | input | 3 | Current interrupt mask level |
| take | input | 1 | Consumer takes the shown request |
| fetch_fault | input | 1 | Handler fetch failed (qualified by take) |
| sel_valid | output | 1 | A request is eligible |
| sel_vec | output | 8 | Vector of the chosen request |
| wake | output | 1 | Release from stopped state |
| halted | output | 1 | Sticky unrecoverable fault |

## Verification
The bench posts mixed-class sets and checks the complete service order.

- A ranking keyed on vector number instead of class would serve vector 40 or vector 70 too early.
- A reversed tie-break would pick 100 over 24.
- An off-by-one in the mask comparison would either release a level-5 request under mask 5 or keep it stuck under mask 4.
- A wrong fault path would post vector 2 for a failed interrupt, or loop on vector 2 instead of halting.
- A reset take that failed to flush would leave requests showing afterwards.
- The bench also checks that reposting a pending vector leaves nothing behind after one take.

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int VW = 8,
  parameter int MW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          post_valid,
  input  logic [VW-1:0] post_vec,
  input  logic [MW-1:0] irq_mask,
  input  logic          take,
  input  logic          fetch_fault,
  output logic          sel_valid,
  output logic [VW-1:0] sel_vec,
  output logic          wake,
  output logic          halted
);
  localparam int NV = 1 << VW;

  logic [NV-1:0] pend, pend_nx;
  logic [2:0]    best_c;
  logic          taken;

  function automatic logic is_irq(input logic [VW-1:0] v);
    int n;
    n = int'(v);
    return (n >= 25 && n <= 31) || (n >= 57 && n <= 63);
  endfunction

  function automatic logic [2:0] cls(input logic [VW-1:0] v);
    int n;
    n = int'(v);
    if (n == 3) return 3'd0;
    if (n == 2) return 3'd1;
    if (n == 9) return 3'd2;
    if ((n >= 24 && n <= 31) || n >= 64) return 3'd3;
    if (n == 4) return 3'd4;
    if (n == 8) return 3'd5;
    return 3'd6;
  endfunction

  function automatic logic elig(input logic [VW-1:0] v, input logic [MW-1:0] m);
    return !is_irq(v) || (v[2:0] > m);
  endfunction

  always_comb begin
    best_c    = 3'd7;
    sel_vec   = '0;
    sel_valid = 1'b0;
    for (int i = NV - 1; i >= 0; i--) begin
      if (pend[i] && elig(VW'(i), irq_mask) && cls(VW'(i)) <= best_c) begin
        best_c    = cls(VW'(i));
        sel_vec   = VW'(i);
        sel_valid = 1'b1;
      end
    end
    if (pend[0]) begin
      sel_vec   = '0;
      sel_valid = 1'b1;
    end
  end

  assign taken = take && sel_valid;
  assign wake  = post_valid && (post_vec == '0 || int'(post_vec) == 9 || is_irq(post_vec));

  always_comb begin
    pend_nx = pend;
    if (taken) begin
      if (sel_vec == '0) pend_nx = '0;
      else begin
        pend_nx[sel_vec] = 1'b0;
        if (fetch_fault) begin
          if (is_irq(sel_vec)) pend_nx[24] = 1'b1;
          else if (int'(sel_vec) != 2) pend_nx[2] = 1'b1;
        end
      end
    end
    if (post_valid) pend_nx[post_vec] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= '0;
      halted <= 1'b0;
    end else begin
      pend <= pend_nx;
      if (taken && fetch_fault && int'(sel_vec) == 2) halted <= 1'b1;
    end
  end
endmodule

module exc_arbiter_chk #(
  parameter int VW = 8,
  parameter int MW = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             post_valid,
  input logic [MW-1:0]    irq_mask,
  input logic             sel_valid,
  input logic [VW-1:0]    sel_vec,
  input logic             wake,
  input logic             halted,
  input logic [(1<<VW)-1:0] pend
);
  logic sel_is_irq;
  assign sel_is_irq = (sel_vec >= VW'(25) && sel_vec <= VW'(31)) ||
                      (sel_vec >= VW'(57) && sel_vec <= VW'(63));

  a_r1_empty_idle: assert property (@(posedge clk) disable iff (rst)
    pend == '0 |-> !sel_valid);
  a_r2_shown_is_pending: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> pend[sel_vec]);
  a_r5_masked_hidden: assert property (@(posedge clk) disable iff (rst)
    sel_valid && sel_is_irq |-> sel_vec[2:0] > irq_mask);
  a_r6_reset_first: assert property (@(posedge clk) disable iff (rst)
    pend[0] |-> sel_valid && sel_vec == '0);
  a_r7_wake_needs_post: assert property (@(posedge clk) disable iff (rst)
    wake |-> post_valid);
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
endmodule

bind exc_arbiter exc_arbiter_chk #(.VW(VW), .MW(MW)) u_chk (
  .clk(clk), .rst(rst), .post_valid(post_valid), .irq_mask(irq_mask),
  .sel_valid(sel_valid), .sel_vec(sel_vec), .wake(wake), .halted(halted),
  .pend(pend)
);

// File: tb/exc_arbiter_bench.sv
module exc_arbiter_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, post_valid = 0, take = 0, fetch_fault = 0;
  logic [7:0] post_vec = '0;
  logic [2:0] irq_mask = '0;
  logic sel_valid, wake, halted;
  logic [7:0] sel_vec;
  int checks = 0, errors = 0;

  exc_arbiter u_exc_arbiter (
    .clk(clk), .rst(rst), .post_valid(post_valid), .post_vec(post_vec),
    .irq_mask(irq_mask), .take(take), .fetch_fault(fetch_fault),
    .sel_valid(sel_valid), .sel_vec(sel_vec), .wake(wake), .halted(halted)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic post(input int v);
    @(negedge clk);
    post_valid = 1; post_vec = 8'(v);
    @(negedge clk);
    post_valid = 0;
  endtask

  task automatic ack(input logic f);
    @(negedge clk);
    take = 1; fetch_fault = f;
    @(negedge clk);
    take = 0; fetch_fault = 0;
  endtask

  task automatic expect_sel(input string req, input int v);
    chk(req, int'(sel_valid), 1);
    chk(req, int'(sel_vec), v);
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk);
    rst = 0;
    chk("R1 valid", int'(sel_valid), 0);
    chk("R1 halted", int'(halted), 0);
  endtask

  task automatic t_basic;
    post(4);
    expect_sel("R2 shown", 4);
    ack(0);
    chk("R2 cleared", int'(sel_valid), 0);
  endtask

  task automatic t_order;
    int exp_seq[7] = '{3, 2, 9, 70, 4, 8, 40};
    post(8); post(4); post(40); post(70); post(9); post(2); post(3);
    foreach (exp_seq[k]) begin
      expect_sel("R3 order", exp_seq[k]);
      ack(0);
    end
    chk("R3 drained", int'(sel_valid), 0);
  endtask

  task automatic t_tie;
    post(100); post(64); post(24);
    expect_sel("R4 tie", 24); ack(0);
    expect_sel("R4 tie", 64); ack(0);
    expect_sel("R4 tie", 100); ack(0);
  endtask

  task automatic t_mask;
    irq_mask = 3'd5;
    post(29); post(62);
    expect_sel("R5 level6", 62); ack(0);
    chk("R5 level5 held", int'(sel_valid), 0);
    @(negedge clk); irq_mask = 3'd4; #1;
    expect_sel("R5 released", 29); ack(0);
    irq_mask = 3'd0;
  endtask

  task automatic t_reset_vec;
    post(4); post(9); post(0);
    expect_sel("R6 reset wins", 0);
    ack(0);
    chk("R6 flushed", int'(sel_valid), 0);
  endtask

  task automatic t_wake;
    int vs[7] = '{9, 27, 60, 24, 4, 32, 0};
    int ws[7] = '{1, 1, 1, 0, 0, 0, 1};
    foreach (vs[k]) begin
      @(negedge clk);
      post_valid = 1; post_vec = 8'(vs[k]); #1;
      chk("R7 wake", int'(wake), ws[k]);
      @(negedge clk);
      post_valid = 0; #1;
      chk("R7 idle", int'(wake), 0);
    end
    ack(0);
  endtask

  task automatic t_fault_irq;
    post(26);
    expect_sel("R8 irq", 26);
    ack(1);
    expect_sel("R8 spurious", 24);
    ack(0);
    chk("R8 drained", int'(sel_valid), 0);
  endtask

  task automatic t_dup;
    post(5); post(5);
    expect_sel("R10 dup", 5);
    ack(0);
    chk("R10 one take", int'(sel_valid), 0);
  endtask

  task automatic t_fault;
    post(4);
    ack(1);
    expect_sel("R9 access err", 2);
    ack(1);
    chk("R9 halted", int'(halted), 1);
    chk("R9 no repost", int'(sel_valid), 0);
    repeat (3) @(negedge clk);
    chk("R9 sticky", int'(halted), 1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_order();
    t_tie();
    t_mask();
    t_reset_vec();
    t_wake();
    t_fault_irq();
    t_dup();
    t_fault();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule